// File: doc/BRIEF.md
# Fixed-Width Instruction Field Decoder

This block is a purely combinational decoder for 32-bit fixed-length instructions of a load/store register machine. A single 6-bit opcode in the top bits selects one of three layouts: a register layout, an immediate layout, or a jump layout. In the register layout, a 6-bit function code in the low bits picks the operation. The decoder slices the word into its fields and produces the control set that a datapath needs. That set covers register indices, the ALU operation and operand source, an extended immediate, memory access enables with size and signedness, and control-transfer flags.

The destination index depends on the layout. Register-layout operations write the third register field. Immediate-layout operations write the second register field. Jump-and-link writes register 31. When an opcode or function code is not recognised, the decoder raises a flag and holds every enable and control-transfer flag low.

Top module: `insn_field_decode`

## Requirements
- R1: Field slicing is fixed for every word: rs = bits 25:21, rt = bits 20:16, shamt = bits 10:6, target = bits 25:0.
- R2: Opcode 0 decodes the function code into the ALU code (ALU codes: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 slt, 7 sltu, 8 sll, 9 srl, 10 sra, 11 pass-immediate). The function codes are 32/33 add, 34/35 sub, 36 and, 37 or, 38 xor, 39 nor, 42 slt, 43 sltu, 0 sll, 2 srl, 3 sra. Each of these sets reg_we, selects the register operand and uses the rd field (bits 15:11) as the destination.
- R3: Immediate ALU opcodes write rt with the immediate operand selected. Opcodes 8/9 give add, 10 gives slt and 11 gives sltu, all with a sign-extended immediate. Opcodes 12/13/14 give and/or/xor with a zero-extended immediate.
- R4: Opcode 15 outputs the 16-bit constant in the upper half of imm_o with the lower half zero, uses ALU code 11 and writes rt.
- R5: Loads set mem_rd, write rt, use ALU add on a sign-extended displacement and report their size (0 byte, 1 half, 2 word) and signedness. The load opcodes are 32 byte, 33 half, 35 word, 36 unsigned byte and 37 unsigned half.
- R6: Stores set mem_wr with no register write and report their size. The store opcodes are 40 byte, 41 half and 43 word.
- R7: Opcode 4 (branch if equal) and opcode 5 (branch if not equal) set branch_o. Opcode 5 also sets branch_ne_o. Both use ALU sub on two registers, write nothing, and carry a sign-extended displacement.
- R8: Opcode 2 sets jump_o. Opcode 3 sets jump_o and link_o, asserts reg_we and makes the destination 31.
- R9: Opcode 0 with function code 8 sets jump_reg_o and writes nothing.
- R10: An unrecognised opcode, or opcode 0 with an unrecognised function code, sets illegal_o. In that case reg_we, mem_rd, mem_wr, branch, jump, link and jump_reg are all low.
- R11: mem_rd and mem_wr are never both high, and at most one of branch, jump and jump_reg is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| rs_o | output | 5 | First source register index |
| rt_o | output | 5 | Second source register index |
| rd_o | output | 5 | Destination register index |
| shamt_o | output | 5 | Shift amount field |
| target_o | output | 26 | Jump target field |
| imm_o | output | 32 | Extended immediate |
| alu_op_o | output | 4 | ALU operation code |
| alu_src_imm_o | output | 1 | Second ALU operand is the immediate |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| mem_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_unsigned_o | output | 1 | Load is zero-extended |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch condition is not-equal |
| jump_o | output | 1 | Jump to target field |
| link_o | output | 1 | Return address is written to register 31 |
| jump_reg_o | output | 1 | Jump to register value |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
Some properties are checked by assertions on every evaluation. Illegal words never carry an enable. Memory reads and writes, and the three control transfers, are mutually exclusive. A link always points the destination at register 31. The pass-immediate code always comes with a zero lower half of imm_o, and a zero-extended logical immediate never has upper bits set. Other behaviour only the bench scenarios can show. This covers the exact opcode and function-code mapping, which layout field becomes the destination, and the sign or zero extension of specific constants. It also covers which words fall into the illegal set, which is shown by random words against an independent model.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned FN_W   = 6;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned TGT_W  = ILEN - OPC_W;
  localparam int unsigned ALU_W  = 4;
  localparam logic [REG_W-1:0] LINK_REG = '1;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_XOR = 4'd4, ALU_NOR = 4'd5, ALU_SLT = 4'd6, ALU_SLTU = 4'd7,
    ALU_SLL = 4'd8, ALU_SRL = 4'd9, ALU_SRA = 4'd10, ALU_PASS = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_UPPER} ext_e;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} msize_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    src_imm;
    ext_e    ext;
    dst_e    dst;
    logic    reg_we;
    logic    mem_rd;
    logic    mem_wr;
    msize_e  msize;
    logic    muns;
    logic    branch;
    logic    branch_ne;
    logic    jump;
    logic    link;
    logic    jump_reg;
    logic    illegal;
  } ctrl_t;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'd0,  OP_J    = 6'd2,  OP_JAL  = 6'd3;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'd4,  OP_BNE  = 6'd5;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'd8,  OP_ADDIU = 6'd9, OP_SLTI = 6'd10, OP_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OP_ANDI  = 6'd12, OP_ORI  = 6'd13, OP_XORI = 6'd14, OP_LUI = 6'd15;
  localparam logic [OPC_W-1:0] OP_LB    = 6'd32, OP_LH   = 6'd33, OP_LW   = 6'd35;
  localparam logic [OPC_W-1:0] OP_LBU   = 6'd36, OP_LHU  = 6'd37;
  localparam logic [OPC_W-1:0] OP_SB    = 6'd40, OP_SH   = 6'd41, OP_SW   = 6'd43;

  localparam logic [FN_W-1:0] FN_SLL = 6'd0,  FN_SRL = 6'd2,  FN_SRA = 6'd3,  FN_JR = 6'd8;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32, FN_ADDU = 6'd33, FN_SUB = 6'd34, FN_SUBU = 6'd35;
  localparam logic [FN_W-1:0] FN_AND = 6'd36, FN_OR = 6'd37, FN_XOR = 6'd38, FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42, FN_SLTU = 6'd43;
endpackage

// File: rtl/insn_fields.sv
module insn_fields
  import insn_dec_pkg::*;
(
  input  logic [ILEN-1:0]  insn_i,
  output logic [OPC_W-1:0] opcode_o,
  output logic [REG_W-1:0] rs_o,
  output logic [REG_W-1:0] rt_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] shamt_o,
  output logic [FN_W-1:0]  funct_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [TGT_W-1:0] target_o
);
  localparam int unsigned RS_LSB = TGT_W - REG_W;
  localparam int unsigned RT_LSB = RS_LSB - REG_W;
  localparam int unsigned RD_LSB = RT_LSB - REG_W;
  localparam int unsigned SH_LSB = RD_LSB - REG_W;

  assign opcode_o = insn_i[ILEN-1 -: OPC_W];
  assign rs_o     = insn_i[RS_LSB +: REG_W];
  assign rt_o     = insn_i[RT_LSB +: REG_W];
  assign rd_o     = insn_i[RD_LSB +: REG_W];
  assign shamt_o  = insn_i[SH_LSB +: REG_W];
  assign funct_o  = insn_i[FN_W-1:0];
  assign imm_o    = insn_i[IMM_W-1:0];
  assign target_o = insn_i[TGT_W-1:0];
endmodule

// File: rtl/insn_ctrl.sv
module insn_ctrl
  import insn_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output ctrl_t            ctrl_o
);
  ctrl_t c;

  always_comb begin
    c = '0;
    c.alu_op = ALU_ADD;
    c.ext    = EXT_SIGN;
    c.dst    = DST_RT;
    c.msize  = SZ_BYTE;
    unique case (opcode_i)
      OP_RTYPE: begin
        c.dst    = DST_RD;
        c.reg_we = 1'b1;
        unique case (funct_i)
          FN_ADD, FN_ADDU: c.alu_op = ALU_ADD;
          FN_SUB, FN_SUBU: c.alu_op = ALU_SUB;
          FN_AND:  c.alu_op = ALU_AND;
          FN_OR:   c.alu_op = ALU_OR;
          FN_XOR:  c.alu_op = ALU_XOR;
          FN_NOR:  c.alu_op = ALU_NOR;
          FN_SLT:  c.alu_op = ALU_SLT;
          FN_SLTU: c.alu_op = ALU_SLTU;
          FN_SLL:  c.alu_op = ALU_SLL;
          FN_SRL:  c.alu_op = ALU_SRL;
          FN_SRA:  c.alu_op = ALU_SRA;
          FN_JR: begin
            c.reg_we   = 1'b0;
            c.jump_reg = 1'b1;
          end
          default: c.illegal = 1'b1;
        endcase
      end
      OP_J:   c.jump = 1'b1;
      OP_JAL: begin
        c.jump   = 1'b1;
        c.link   = 1'b1;
        c.reg_we = 1'b1;
        c.dst    = DST_LINK;
      end
      OP_BEQ, OP_BNE: begin
        c.branch    = 1'b1;
        c.branch_ne = (opcode_i == OP_BNE);
        c.alu_op    = ALU_SUB;
      end
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: begin
        c.reg_we  = 1'b1;
        c.src_imm = 1'b1;
        c.alu_op  = (opcode_i == OP_SLTI)  ? ALU_SLT  :
                    (opcode_i == OP_SLTIU) ? ALU_SLTU : ALU_ADD;
      end
      OP_ANDI, OP_ORI, OP_XORI: begin
        c.reg_we  = 1'b1;
        c.src_imm = 1'b1;
        c.ext     = EXT_ZERO;
        c.alu_op  = (opcode_i == OP_ANDI) ? ALU_AND :
                    (opcode_i == OP_ORI)  ? ALU_OR  : ALU_XOR;
      end
      OP_LUI: begin
        c.reg_we  = 1'b1;
        c.src_imm = 1'b1;
        c.ext     = EXT_UPPER;
        c.alu_op  = ALU_PASS;
      end
      OP_LB, OP_LH, OP_LW, OP_LBU, OP_LHU: begin
        c.reg_we  = 1'b1;
        c.src_imm = 1'b1;
        c.mem_rd  = 1'b1;
        c.muns    = (opcode_i == OP_LBU) || (opcode_i == OP_LHU);
        c.msize   = (opcode_i == OP_LW) ? SZ_WORD :
                    (opcode_i == OP_LH || opcode_i == OP_LHU) ? SZ_HALF : SZ_BYTE;
      end
      OP_SB, OP_SH, OP_SW: begin
        c.src_imm = 1'b1;
        c.mem_wr  = 1'b1;
        c.msize   = (opcode_i == OP_SW) ? SZ_WORD :
                    (opcode_i == OP_SH) ? SZ_HALF : SZ_BYTE;
      end
      default: c.illegal = 1'b1;
    endcase
    // illegal words carry no side effects
    if (c.illegal) begin
      c = '0;
      c.illegal = 1'b1;
      c.alu_op  = ALU_ADD;
      c.ext     = EXT_SIGN;
      c.dst     = DST_RT;
      c.msize   = SZ_BYTE;
    end
  end

  assign ctrl_o = c;

  always_comb begin
    p_illegal_quiet_r10: assert (!(ctrl_o.illegal && (ctrl_o.reg_we || ctrl_o.mem_rd ||
      ctrl_o.mem_wr || ctrl_o.branch || ctrl_o.jump || ctrl_o.link || ctrl_o.jump_reg)));
    p_mem_excl_r11: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr));
    p_xfer_excl_r11: assert ($countones({ctrl_o.branch, ctrl_o.jump, ctrl_o.jump_reg}) <= 1);
  end
endmodule

// File: rtl/insn_imm_ext.sv
module insn_imm_ext
  import insn_dec_pkg::*;
#(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  imm_i,
  input  ext_e             ext_i,
  output logic [OUT_W-1:0] imm_o
);
  localparam int unsigned PAD_W = OUT_W - IN_W;

  always_comb begin
    unique case (ext_i)
      EXT_ZERO:  imm_o = {{PAD_W{1'b0}}, imm_i};
      EXT_UPPER: imm_o = {imm_i, {PAD_W{1'b0}}};
      default:   imm_o = {{PAD_W{imm_i[IN_W-1]}}, imm_i};
    endcase
  end
endmodule

// File: rtl/insn_field_decode.sv
module insn_field_decode
  import insn_dec_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic [4:0]  rs_o,
  output logic [4:0]  rt_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  shamt_o,
  output logic [25:0] target_o,
  output logic [31:0] imm_o,
  output logic [3:0]  alu_op_o,
  output logic        alu_src_imm_o,
  output logic        reg_we_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [1:0]  mem_size_o,
  output logic        mem_unsigned_o,
  output logic        branch_o,
  output logic        branch_ne_o,
  output logic        jump_o,
  output logic        link_o,
  output logic        jump_reg_o,
  output logic        illegal_o
);
  logic [OPC_W-1:0] opcode;
  logic [REG_W-1:0] rd_field;
  logic [FN_W-1:0]  funct;
  logic [IMM_W-1:0] imm16;
  ctrl_t            ctrl;

  insn_fields u_fields (
    .insn_i  (insn_i),
    .opcode_o(opcode),
    .rs_o    (rs_o),
    .rt_o    (rt_o),
    .rd_o    (rd_field),
    .shamt_o (shamt_o),
    .funct_o (funct),
    .imm_o   (imm16),
    .target_o(target_o)
  );

  insn_ctrl u_ctrl (
    .opcode_i(opcode),
    .funct_i (funct),
    .ctrl_o  (ctrl)
  );

  insn_imm_ext #(.IN_W(IMM_W), .OUT_W(ILEN)) u_ext (
    .imm_i(imm16),
    .ext_i(ctrl.ext),
    .imm_o(imm_o)
  );

  always_comb begin
    unique case (ctrl.dst)
      DST_RD:   rd_o = rd_field;
      DST_LINK: rd_o = LINK_REG;
      default:  rd_o = rt_o;
    endcase
  end

  assign alu_op_o       = ctrl.alu_op;
  assign alu_src_imm_o  = ctrl.src_imm;
  assign reg_we_o       = ctrl.reg_we;
  assign mem_rd_o       = ctrl.mem_rd;
  assign mem_wr_o       = ctrl.mem_wr;
  assign mem_size_o     = ctrl.msize;
  assign mem_unsigned_o = ctrl.muns;
  assign branch_o       = ctrl.branch;
  assign branch_ne_o    = ctrl.branch_ne;
  assign jump_o         = ctrl.jump;
  assign link_o         = ctrl.link;
  assign jump_reg_o     = ctrl.jump_reg;
  assign illegal_o      = ctrl.illegal;

  always_comb begin
    p_link_dest_r8: assert (!link_o || (rd_o == LINK_REG && reg_we_o));
    p_upper_low_zero_r4: assert (alu_op_o != ALU_PASS || imm_o[IMM_W-1:0] == '0);
    p_zext_high_zero_r3: assert (!(alu_src_imm_o && (alu_op_o == ALU_AND ||
      alu_op_o == ALU_OR || alu_op_o == ALU_XOR)) || imm_o[ILEN-1:IMM_W] == '0);
  end
endmodule

// File: tb/insn_field_decode_bench.sv
module insn_field_decode_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] insn;
  logic [4:0]  rs, rt, rd, shamt;
  logic [25:0] target;
  logic [31:0] imm;
  logic [3:0]  alu_op;
  logic        src_imm, we, mrd, mwr, muns, br, bne, jmp, lnk, jr, ill;
  logic [1:0]  msize;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  insn_field_decode u_insn_field_decode (
    .insn_i(insn), .rs_o(rs), .rt_o(rt), .rd_o(rd), .shamt_o(shamt),
    .target_o(target), .imm_o(imm), .alu_op_o(alu_op), .alu_src_imm_o(src_imm),
    .reg_we_o(we), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_size_o(msize),
    .mem_unsigned_o(muns), .branch_o(br), .branch_ne_o(bne), .jump_o(jmp),
    .link_o(lnk), .jump_reg_o(jr), .illegal_o(ill)
  );

  typedef struct {
    string       tag;
    logic [4:0]  dest;
    logic [31:0] imm;
    logic [3:0]  alu;
    logic        src_imm, we, mrd, mwr, muns, br, bne, jmp, lnk, jr, ill;
    logic [1:0]  msize;
  } exp_t;

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    logic [31:0] sx = {{16{w[15]}}, w[15:0]};
    e.tag = "R10"; e.dest = w[20:16]; e.imm = sx; e.alu = 4'd0;
    e.src_imm = 0; e.we = 0; e.mrd = 0; e.mwr = 0; e.muns = 0; e.br = 0;
    e.bne = 0; e.jmp = 0; e.lnk = 0; e.jr = 0; e.ill = 0; e.msize = 2'd0;
    case (op)
      6'd0: begin
        e.tag = "R2"; e.dest = w[15:11]; e.we = 1;
        case (fn)
          6'd32, 6'd33: e.alu = 4'd0;
          6'd34, 6'd35: e.alu = 4'd1;
          6'd36: e.alu = 4'd2;  6'd37: e.alu = 4'd3;
          6'd38: e.alu = 4'd4;  6'd39: e.alu = 4'd5;
          6'd42: e.alu = 4'd6;  6'd43: e.alu = 4'd7;
          6'd0:  e.alu = 4'd8;  6'd2:  e.alu = 4'd9;  6'd3: e.alu = 4'd10;
          6'd8: begin e.tag = "R9"; e.we = 0; e.jr = 1; end
          default: begin e.tag = "R10"; e.we = 0; e.ill = 1; end
        endcase
      end
      6'd2: begin e.tag = "R8"; e.jmp = 1; end
      6'd3: begin e.tag = "R8"; e.jmp = 1; e.lnk = 1; e.we = 1; e.dest = 5'd31; end
      6'd4, 6'd5: begin e.tag = "R7"; e.br = 1; e.bne = (op == 6'd5); e.alu = 4'd1; end
      6'd8, 6'd9, 6'd10, 6'd11: begin
        e.tag = "R3"; e.we = 1; e.src_imm = 1;
        e.alu = (op == 6'd10) ? 4'd6 : (op == 6'd11) ? 4'd7 : 4'd0;
      end
      6'd12, 6'd13, 6'd14: begin
        e.tag = "R3"; e.we = 1; e.src_imm = 1; e.imm = {16'h0, w[15:0]};
        e.alu = (op == 6'd12) ? 4'd2 : (op == 6'd13) ? 4'd3 : 4'd4;
      end
      6'd15: begin e.tag = "R4"; e.we = 1; e.src_imm = 1; e.alu = 4'd11; e.imm = {w[15:0], 16'h0}; end
      6'd32, 6'd33, 6'd35, 6'd36, 6'd37: begin
        e.tag = "R5"; e.we = 1; e.src_imm = 1; e.mrd = 1;
        e.muns = (op == 6'd36) || (op == 6'd37);
        e.msize = (op == 6'd35) ? 2'd2 : (op == 6'd33 || op == 6'd37) ? 2'd1 : 2'd0;
      end
      6'd40, 6'd41, 6'd43: begin
        e.tag = "R6"; e.src_imm = 1; e.mwr = 1;
        e.msize = (op == 6'd43) ? 2'd2 : (op == 6'd41) ? 2'd1 : 2'd0;
      end
      default: begin e.tag = "R10"; e.ill = 1; end
    endcase
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s insn=%h actual=%h expected=%h", req, what, insn, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    exp_t e;
    @(posedge clk);
    insn = w;
    @(negedge clk);
    e = model(w);
    chk("R1", "rs", 32'(rs), 32'(w[25:21]));
    chk("R1", "rt", 32'(rt), 32'(w[20:16]));
    chk("R1", "shamt", 32'(shamt), 32'(w[10:6]));
    chk("R1", "target", 32'(target), 32'(w[25:0]));
    chk(e.tag, "illegal", 32'(ill), 32'(e.ill));
    chk(e.tag, "imm", imm, e.imm);
    chk(e.tag, "alu_op", 32'(alu_op), 32'(e.alu));
    chk(e.tag, "src_imm", 32'(src_imm), 32'(e.src_imm));
    chk(e.tag, "reg_we", 32'(we), 32'(e.we));
    if (e.we) chk(e.tag, "dest", 32'(rd), 32'(e.dest));
    chk(e.tag, "mem_rd", 32'(mrd), 32'(e.mrd));
    chk(e.tag, "mem_wr", 32'(mwr), 32'(e.mwr));
    if (e.mrd || e.mwr) chk(e.tag, "mem_size", 32'(msize), 32'(e.msize));
    if (e.mrd) chk(e.tag, "mem_unsigned", 32'(muns), 32'(e.muns));
    chk(e.tag, "branch", 32'(br), 32'(e.br));
    chk(e.tag, "branch_ne", 32'(bne), 32'(e.bne));
    chk(e.tag, "jump", 32'(jmp), 32'(e.jmp));
    chk(e.tag, "link", 32'(lnk), 32'(e.lnk));
    chk(e.tag, "jump_reg", 32'(jr), 32'(e.jr));
    chk("R11", "mem_excl", 32'(mrd & mwr), 32'h0);
    chk("R11", "xfer_excl", 32'(br + jmp + jr > 1), 32'h0);
  endtask

  localparam logic [5:0] OPS [22] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd9, 6'd10,
    6'd11, 6'd12, 6'd13, 6'd14, 6'd15, 6'd32, 6'd33, 6'd35, 6'd36, 6'd37, 6'd40,
    6'd41, 6'd43, 6'd1};
  localparam logic [5:0] FNS [14] = '{6'd0, 6'd2, 6'd3, 6'd8, 6'd32, 6'd33, 6'd34,
    6'd35, 6'd36, 6'd37, 6'd38, 6'd39, 6'd42, 6'd43};

  initial begin
    logic [31:0] w;
    insn = 32'h0;
    @(negedge clk);
    // R2: add r1,r2,r3
    apply(32'h0043_0820);
    chk("R2", "add dest rd", 32'(rd), 32'd1);
    apply(32'h0000_0000);            // R2 sll r0,r0,0
    apply(32'h0021_0003 | (5'd7 << 6)); // R2 sra with shamt 7
    apply(32'h2022_8001);            // R3 addi negative, sign-extended
    chk("R3", "addi sext", imm, 32'hFFFF_8001);
    apply(32'h3022_8001);            // R3 andi zero-extended
    chk("R3", "andi zext", imm, 32'h0000_8001);
    apply(32'h3C01_ABCD);            // R4 lui
    chk("R4", "lui imm", imm, 32'hABCD_0000);
    apply(32'h9445_FFFC);            // R5 lhu
    apply(32'h8C45_0004);            // R5 lw
    apply(32'hA045_FFFF);            // R6 sb
    apply(32'h1485_FFFE);            // R7 bne
    apply(32'h1085_0010);            // R7 beq
    apply(32'h0800_1234);            // R8 j
    apply(32'h0FFF_FFFF);            // R8 jal
    chk("R8", "jal dest 31", 32'(rd), 32'd31);
    apply(32'h03E0_0008);            // R9 jr r31
    apply(32'hFC00_0000);            // R10 opcode 63
    apply(32'h0043_0801);            // R10 funct 1
    apply(32'h0043_082C);            // R10 funct 44
    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      w = $urandom();
      case ($urandom_range(2, 0))
        0: w[31:26] = OPS[$urandom_range(21, 0)];
        1: begin w[31:26] = 6'd0; w[5:0] = FNS[$urandom_range(13, 0)]; end
        default: ;
      endcase
      apply(w);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule